// File: doc/BRIEF.md
# I/O-Mapped Watchdog Timer

This block guards a processor against a hung program. It watches a plain I/O read strobe and its address bus. The first read of the arm port starts a timeout. Each later read of the same port starts the timeout again from zero. A read of the disarm port stops it. If the timer stays armed and no restart read arrives within the selected period, the block acts. It either drives a fixed-length system reset pulse or raises a non-maskable interrupt request.

Board straps choose the action and the period. The action strap picks reset, NMI, or no watchdog at all. The period strap picks one of six timeouts between 1 and 220 seconds. A prescaler turns the system clock into a slow tick, and the period is counted in those ticks. The straps are latched only when the timer is armed or restarted, so a period that is already running is never changed.

Top module: `io_watchdog`

## Requirements
- R1: A read of address ARM_ADDR (default 0x0443) arms the timer when the action strap is 2'b01 or 2'b10. The timeout count then starts from zero.
- R2: While the timer is armed, each read of ARM_ADDR restarts the count from zero. A restart read in the very cycle the period would expire takes priority, and no action occurs.
- R3: A read of DISARM_ADDR (default 0x0043) disarms the timer. No timeout action follows.
- R4: period_strap selects the period. Bit 1 alone gives 1 s, bit 2 alone gives 10 s and bit 3 alone gives 110 s. Bit 0 doubles any of these bases. Any other combination of bits 3..1 gives 10 s, with no doubling. The action fires exactly seconds*TICKS_PER_SEC*PRESCALE clock cycles after the clock edge that took the arming or restart read.
- R5: With action 2'b01, a timeout drives sys_reset_o high for RST_PULSE cycles (default 16). It starts in the cycle after the expiry edge.
- R6: With action 2'b10, a timeout sets nmi_req_o. It stays high until the next read of either decoded address.
- R7: With action 2'b00 or 2'b11, a read of ARM_ADDR leaves the timer disarmed. If the timer is already armed, such a read disarms it. No output is ever driven in this case.
- R8: After a timeout the timer is disarmed. No further action occurs until it is armed again.
- R9: Changes to either strap while the timer is armed have no effect until the next arm or restart read.
- R10: Only the rising edge of io_rd counts as a read. A strobe held high counts once, and reads of any other address are ignored.
- R11: After a synchronous reset both outputs are low and the timer is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | I/O read strobe, active high |
| io_addr | input | ADDR_W | I/O address, valid while io_rd is high |
| period_strap | input | 4 | Timeout period straps; bits 3..1 select the base, bit 0 doubles it |
| action_strap | input | 2 | 01 = reset, 10 = NMI, 00/11 = watchdog off |
| sys_reset_o | output | 1 | System reset pulse |
| nmi_req_o | output | 1 | Non-maskable interrupt request |

## Verification
Two functions can fall in the same cycle: a restart or disarm read, and the expiry of the count. The bench places a read exactly on the expiry edge, then one cycle earlier. It also places a disarm read on the expiry edge. For each case, a clock-by-clock behavioural model decides whether any action may appear, and the output is compared every cycle. In NMI mode, a new arm read while the request is still held both clears the request and restarts the count in one cycle. The comparison judges that as well.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ACT_OFF   = 2'b00,
        ACT_RESET = 2'b01,
        ACT_NMI   = 2'b10,
        ACT_RSVD  = 2'b11
    } wdt_act_e;

    // Decoded bus events for one clock cycle
    typedef struct packed {
        logic arm;
        logic disarm;
    } wdt_ev_t;

    // Timeout action requests for one clock cycle
    typedef struct packed {
        logic rst;
        logic nmi;
    } wdt_fire_t;

    function automatic logic act_enabled(input wdt_act_e a);
        return (a == ACT_RESET) || (a == ACT_NMI);
    endfunction

    // Timeout in seconds from the period straps
    function automatic int unsigned period_secs(input logic [3:0] s);
        int unsigned base;
        logic        legal;
        legal = 1'b1;
        case (s[3:1])
            3'b001:  base = 1;
            3'b010:  base = 10;
            3'b100:  base = 110;
            default: begin
                base  = 10;
                legal = 1'b0;
            end
        endcase
        return (legal && s[0]) ? base * 2 : base;
    endfunction

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode
    import wdt_pkg::*;
#(
    parameter int                 ADDR_W      = 16,
    parameter logic [ADDR_W-1:0]  ARM_ADDR    = 'h443,
    parameter logic [ADDR_W-1:0]  DISARM_ADDR = 'h043
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    output wdt_ev_t           ev
);
    logic rd_q;
    logic rd_rise;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= io_rd;
    end

    assign rd_rise   = io_rd && !rd_q;
    assign ev.arm    = rd_rise && (io_addr == ARM_ADDR);
    assign ev.disarm = rd_rise && (io_addr == DISARM_ADDR);

    // A strobe held high produces no second event
    assert_single_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (io_rd && $past(io_rd)) |-> !(ev.arm || ev.disarm));

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRESCALE = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PW = $clog2(PRESCALE + 1);
    localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);

    logic [PW-1:0] pcnt;

    assign tick = en && (pcnt == PMAX);

    always_ff @(posedge clk) begin
        if (rst || clr)   pcnt <= '0;
        else if (tick)    pcnt <= '0;
        else if (en)      pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int TICKS_PER_SEC = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  wdt_ev_t    ev,
    input  logic       tick,
    input  logic [3:0] period_strap,
    input  logic [1:0] action_strap,
    output logic       armed,
    output wdt_fire_t  fire
);
    localparam int MAX_TICKS = 220 * TICKS_PER_SEC;
    localparam int LW        = $clog2(MAX_TICKS + 1);

    logic [LW-1:0] tcnt;
    logic [LW-1:0] lim;
    wdt_act_e      mode;
    wdt_act_e      act_in;
    logic          expire;

    assign act_in = wdt_act_e'(action_strap);
    assign expire = armed && !ev.arm && !ev.disarm && tick
                    && (tcnt == lim - 1'b1);

    assign fire.rst = expire && (mode == ACT_RESET);
    assign fire.nmi = expire && (mode == ACT_NMI);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            tcnt  <= '0;
            lim   <= '0;
            mode  <= ACT_OFF;
        end else if (ev.disarm) begin
            armed <= 1'b0;
        end else if (ev.arm) begin
            armed <= act_enabled(act_in);
            tcnt  <= '0;
            lim   <= LW'(period_secs(period_strap) * TICKS_PER_SEC);
            mode  <= act_in;
        end else if (expire) begin
            armed <= 1'b0;
        end else if (armed && tick) begin
            tcnt  <= tcnt + 1'b1;
        end
    end

    assert_arm_R1: assert property (@(posedge clk) disable iff (rst)
        (ev.arm && act_enabled(act_in)) |=> (armed && tcnt == '0));

    assert_disarm_R3: assert property (@(posedge clk) disable iff (rst)
        ev.disarm |=> !armed);

    assert_off_mode_R7: assert property (@(posedge clk) disable iff (rst)
        (ev.arm && !act_enabled(act_in)) |=> !armed);

    assert_disarm_after_fire_R8: assert property (@(posedge clk) disable iff (rst)
        (fire.rst || fire.nmi) |=> !armed);

    assert_period_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && !ev.arm) |=> $stable(lim));

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
#(
    parameter int RST_PULSE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  wdt_fire_t fire,
    input  logic      clr_nmi,
    output logic      sys_reset_o,
    output logic      nmi_req_o
);
    localparam int RW = $clog2(RST_PULSE + 1);

    logic [RW-1:0] rcnt;
    logic          nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt  <= '0;
            nmi_q <= 1'b0;
        end else begin
            if (fire.rst)        rcnt <= RW'(RST_PULSE);
            else if (rcnt != '0) rcnt <= rcnt - 1'b1;

            if (fire.nmi)        nmi_q <= 1'b1;
            else if (clr_nmi)    nmi_q <= 1'b0;
        end
    end

    assign sys_reset_o = (rcnt != '0);
    assign nmi_req_o   = nmi_q;

    assert_reset_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_reset_o) |-> $past(fire.rst));

    assert_nmi_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (nmi_q && !clr_nmi) |=> nmi_q);

    assert_nmi_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr_nmi |=> !nmi_q);

endmodule

// File: rtl/io_watchdog.sv
module io_watchdog
    import wdt_pkg::*;
#(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] ARM_ADDR      = 'h443,
    parameter logic [ADDR_W-1:0] DISARM_ADDR   = 'h043,
    parameter int                PRESCALE      = 1000000,
    parameter int                TICKS_PER_SEC = 10,
    parameter int                RST_PULSE     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [3:0]        period_strap,
    input  logic [1:0]        action_strap,
    output logic              sys_reset_o,
    output logic              nmi_req_o
);
    wdt_ev_t   ev;
    wdt_fire_t fire;
    logic      armed;
    logic      tick;

    wdt_decode #(
        .ADDR_W      (ADDR_W),
        .ARM_ADDR    (ARM_ADDR),
        .DISARM_ADDR (DISARM_ADDR)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .ev      (ev)
    );

    wdt_prescale #(
        .PRESCALE (PRESCALE)
    ) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .clr  (ev.arm),
        .en   (armed),
        .tick (tick)
    );

    wdt_core #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_core (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .tick         (tick),
        .period_strap (period_strap),
        .action_strap (action_strap),
        .armed        (armed),
        .fire         (fire)
    );

    wdt_action #(
        .RST_PULSE (RST_PULSE)
    ) u_action (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .clr_nmi     (ev.arm || ev.disarm),
        .sys_reset_o (sys_reset_o),
        .nmi_req_o   (nmi_req_o)
    );

endmodule

// File: tb/io_watchdog_test.sv
module io_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 4;
    localparam int TPS = 2;
    localparam int PULSE = 16;
    localparam logic [15:0] A_ARM = 16'h0443;
    localparam logic [15:0] A_DIS = 16'h0043;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  pstrap = 4'b0010;
    logic [1:0]  astrap = 2'b01;
    logic        sys_reset_o;
    logic        nmi_req_o;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R11 reset state";
    bit    done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_watchdog #(
        .ADDR_W        (16),
        .ARM_ADDR      (A_ARM),
        .DISARM_ADDR   (A_DIS),
        .PRESCALE      (P),
        .TICKS_PER_SEC (TPS),
        .RST_PULSE     (PULSE)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .io_rd        (io_rd),
        .io_addr      (io_addr),
        .period_strap (pstrap),
        .action_strap (astrap),
        .sys_reset_o  (sys_reset_o),
        .nmi_req_o    (nmi_req_o)
    );

    // Period in seconds, worked out from the R4 encoding
    function automatic int secs_of(input logic [3:0] s);
        int b;
        if (s[3:1] == 3'b001)      b = 1;
        else if (s[3:1] == 3'b010) b = 10;
        else if (s[3:1] == 3'b100) b = 110;
        else return 10;
        return s[0] ? 2 * b : b;
    endfunction

    // Behavioural reference model, counted in clock cycles
    bit m_started = 1'b0;
    bit m_rd_prev, m_armed, m_nmi;
    int m_elapsed, m_lim, m_mode, m_rcnt;

    always @(posedge clk) begin
        bit rise, hit_a, hit_d;
        m_started = 1'b1;
        if (rst) begin
            m_rd_prev = 0; m_armed = 0; m_nmi = 0;
            m_elapsed = 0; m_lim = 0; m_mode = 0; m_rcnt = 0;
        end else begin
            rise  = io_rd && !m_rd_prev;
            m_rd_prev = io_rd;
            hit_a = rise && (io_addr == A_ARM);
            hit_d = rise && (io_addr == A_DIS);
            if (m_rcnt > 0) m_rcnt--;
            if (hit_a || hit_d) m_nmi = 0;
            if (hit_d) m_armed = 0;
            else if (hit_a) begin
                if (astrap == 2'b01 || astrap == 2'b10) begin
                    m_armed = 1; m_elapsed = 0;
                    m_lim = secs_of(pstrap) * TPS * P;
                    m_mode = int'(astrap);
                end else m_armed = 0;
            end else if (m_armed) begin
                m_elapsed++;
                if (m_elapsed == m_lim) begin
                    m_armed = 0;
                    if (m_mode == 1) m_rcnt = PULSE;
                    else m_nmi = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (m_started && !done) begin
            checks++;
            if (sys_reset_o !== (m_rcnt != 0) || nmi_req_o !== m_nmi) begin
                fails++;
                $display("FAIL %s: reset=%b nmi=%b expected reset=%b nmi=%b at %0t",
                         phase, sys_reset_o, nmi_req_o, (m_rcnt != 0), m_nmi, $time);
            end
        end
    end

    task automatic rd(input logic [15:0] a);
        io_addr = a;
        io_rd   = 1'b1;
        @(negedge clk);
        io_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(4);

        phase = "R1 R5 arm and reset pulse";
        pstrap = 4'b0010; astrap = 2'b01;
        rd(A_ARM); idle(40);
        phase = "R8 no second action after timeout";
        idle(60);

        phase = "R2 repeated restarts";
        pstrap = 4'b0011;
        rd(A_ARM);
        for (int i = 0; i < 5; i++) begin idle(10); rd(A_ARM); end
        idle(40);

        phase = "R2 restart on the expiry edge";
        pstrap = 4'b0010;
        rd(A_ARM); idle(7); rd(A_ARM); idle(40);
        phase = "R2 restart one cycle early";
        rd(A_ARM); idle(6); rd(A_ARM); idle(40);

        phase = "R3 disarm mid period";
        rd(A_ARM); idle(4); rd(A_DIS); idle(40);
        phase = "R3 disarm on the expiry edge";
        rd(A_ARM); idle(7); rd(A_DIS); idle(40);

        phase = "R6 NMI held until a decoded read";
        astrap = 2'b10;
        rd(A_ARM); idle(40);
        rd(A_ARM); idle(40);
        rd(A_DIS); idle(10);

        phase = "R7 off modes";
        astrap = 2'b00; rd(A_ARM); idle(40);
        astrap = 2'b11; rd(A_ARM); idle(40);
        astrap = 2'b01; rd(A_ARM); idle(3);
        astrap = 2'b00; rd(A_ARM); idle(40);

        phase = "R4 period encodings";
        astrap = 2'b01;
        foreach (pstrap_list[k]) begin
            pstrap = pstrap_list[k];
            rd(A_ARM);
            idle(secs_of(pstrap_list[k]) * TPS * P + 30);
        end

        phase = "R9 straps frozen while armed";
        pstrap = 4'b0010; astrap = 2'b01;
        rd(A_ARM); pstrap = 4'b1001; astrap = 2'b10; idle(40);
        astrap = 2'b10; pstrap = 4'b0010;
        rd(A_ARM); astrap = 2'b01; idle(40);
        rd(A_DIS); idle(4);

        phase = "R10 held strobe and foreign addresses";
        astrap = 2'b01; pstrap = 4'b0010;
        io_addr = A_ARM; io_rd = 1'b1; idle(12); io_rd = 1'b0; idle(30);
        rd(A_ARM); rd(16'h0444); rd(16'h1443); rd(16'h0042); idle(40);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [3:0] pstrap_list [9] = '{4'b0010, 4'b0011, 4'b0100, 4'b0101,
                                    4'b1000, 4'b1001, 4'b0000, 4'b0110, 4'b1111};

endmodule